// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words from a write-only three-wire serial port and places them into one of two parallel configuration registers. The port has three lines: a serial clock, a serial data line and a latch-enable line. While latch-enable stays low, each rising edge of the serial clock shifts one data bit into an internal shift register. The most significant bit comes first.

The last bit shifted in is the address. It picks the target register. A rising edge on latch-enable then copies the upper bits of the shift register into that target. The three serial lines are synchronised into the system clock domain, and their edges are detected there. Each configuration register drives a one-cycle strobe whenever it is written, so downstream logic can act on fresh settings.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted and after it is released, reg0_q holds DFLT0 and reg1_q holds DFLT1. Both update strobes stay low until the first latch.
- R2: ser_dat is sampled on each rising edge of ser_clk, and the most significant bit comes first. With an 18-bit word, the first 17 bits shifted form the stored value, first bit at bit 16.
- R3: The last bit shifted before the latch is the address. A value of 0 writes reg0_q and a value of 1 writes reg1_q. The register that is not addressed keeps its value.
- R4: Shifting alone changes no register. A transfer happens only on a rising edge of ser_le. A falling edge of ser_le, and ser_clk edges while ser_le is high, leave both registers unchanged.
- R5: Only the 17 bits above the address bit are stored. The address bit is not part of the stored value.
- R6: When more than 18 serial clock edges arrive before a latch, only the most recent 18 bits are used.
- R7: Each latch raises exactly one strobe, reg0_upd or reg1_upd, matching the address, for exactly one system clock cycle. The strobe is high in the same cycle the new value first appears. A register changes only in a cycle where its strobe is high.
- R8: Reset clears the shift register. A latch after only k < 18 bits following reset behaves as if zeros came before those k bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| ser_le | input | 1 | Latch-enable line, asynchronous |
| reg0_q | output | WORD_W-1 | Configuration register for address 0 |
| reg1_q | output | WORD_W-1 | Configuration register for address 1 |
| reg0_upd | output | 1 | One-cycle strobe when reg0_q is written |
| reg1_upd | output | 1 | One-cycle strobe when reg1_q is written |

## Verification
The bench uses the default build: an 18-bit word, two synchroniser stages, and distinct non-zero defaults for the two registers. With non-zero defaults, a reset that clears a register is told apart from a load of zeros. With the full 18-bit shift path, frames of 18 to 24 bits are possible, so the bench covers exact-length words, over-length words that must drop their oldest bits, and short words after reset. The serial lines are held for several system clocks per phase, so each serial edge clears the two-stage synchroniser and is seen exactly once.

// File: rtl/serial_cfg_loader_pkg.sv
package serial_cfg_loader_pkg;
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } edge_info_t;
endpackage

// File: rtl/cfgl_sync_edge.sv
module cfgl_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output serial_cfg_loader_pkg::edge_info_t info
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= async_in;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   always_comb begin
      info.level = chain[STAGES-1];
      info.rise  = chain[STAGES-1] & ~prev;
      info.fall  = ~chain[STAGES-1] & prev;
   end
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
   end
endmodule

// File: rtl/cfgl_bank.sv
module cfgl_bank #(
   parameter int              DATA_W = 17,
   parameter logic [DATA_W-1:0] DFLT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q,
   output logic              upd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= DFLT;
         upd <= 1'b0;
      end else begin
         upd <= load;
         if (load) q <= din;
      end
   end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
   parameter int WORD_W      = 18,
   parameter int SYNC_STAGES = 2,
   parameter logic [WORD_W-2:0] DFLT0 = 17'h1A5C3,
   parameter logic [WORD_W-2:0] DFLT1 = 17'h0F0F1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   output logic [WORD_W-2:0] reg0_q,
   output logic [WORD_W-2:0] reg1_q,
   output logic              reg0_upd,
   output logic              reg1_upd
);
   import serial_cfg_loader_pkg::*;

   localparam int DATA_W   = WORD_W - 1;
   localparam int NUM_REGS = 2;

   if (WORD_W < 2) begin : g_chk_word
      $error("WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   edge_info_t e_clk, e_dat, e_le;
   logic [WORD_W-1:0] sh_word;
   logic [DATA_W-1:0] bank_q   [NUM_REGS];
   logic              bank_upd [NUM_REGS];

   cfgl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .info(e_clk));
   cfgl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .async_in(ser_dat), .info(e_dat));
   cfgl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_le (
      .clk(clk), .rst_n(rst_n), .async_in(ser_le), .info(e_le));

   cfgl_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .shift_en(e_clk.rise & ~e_le.level),
      .bit_in(e_dat.level),
      .word(sh_word));

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
         localparam logic [DATA_W-1:0] BANK_DFLT = (g == 0) ? DFLT0 : DFLT1;
         cfgl_bank #(.DATA_W(DATA_W), .DFLT(BANK_DFLT)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .load(e_le.rise && (sh_word[0] == g[0])),
            .din(sh_word[WORD_W-1:1]),
            .q(bank_q[g]),
            .upd(bank_upd[g]));
      end
   endgenerate

   assign reg0_q   = bank_q[0];
   assign reg1_q   = bank_q[1];
   assign reg0_upd = bank_upd[0];
   assign reg1_upd = bank_upd[1];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
   parameter int DATA_W = 17,
   parameter logic [DATA_W-1:0] DFLT0 = '0,
   parameter logic [DATA_W-1:0] DFLT1 = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] reg0_q,
   input logic [DATA_W-1:0] reg1_q,
   input logic              reg0_upd,
   input logic              reg1_upd
);
   assert_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (reg0_q == DFLT0 && reg1_q == DFLT1 && !reg0_upd && !reg1_upd));

   assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg0_upd, reg1_upd}));

   assert_strobe_pulse0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg0_upd |=> !reg0_upd);

   assert_strobe_pulse1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg1_upd |=> !reg1_upd);

   assert_reg0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg0_q) |-> reg0_upd);

   assert_reg1_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg1_q) |-> reg1_upd);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
   .DATA_W(WORD_W - 1), .DFLT0(DFLT0), .DFLT1(DFLT1)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .reg0_q(reg0_q), .reg1_q(reg1_q),
   .reg0_upd(reg0_upd), .reg1_upd(reg1_upd));

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
   localparam int W  = 18;
   localparam int DW = W - 1;
   localparam logic [DW-1:0] D0 = 17'h1A5C3;
   localparam logic [DW-1:0] D1 = 17'h0F0F1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic [DW-1:0] reg0_q, reg1_q;
   logic reg0_upd, reg1_upd;

   int total = 0, bad = 0;
   int cnt0 = 0, cnt1 = 0;
   logic [W-1:0]  model_sh;
   logic [DW-1:0] exp0, exp1;
   bit done = 0;

   always #10 clk = ~clk;

   serial_cfg_loader dut_i (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
      .reg0_q(reg0_q), .reg1_q(reg1_q), .reg0_upd(reg0_upd), .reg1_upd(reg1_upd));

   always @(posedge clk) begin
      if (reg0_upd) cnt0 <= cnt0 + 1;
      if (reg1_upd) cnt1 <= cnt1 + 1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [W-1:0] model_shift(input logic [W-1:0] s, input logic b);
      return {s[W-2:0], b};
   endfunction

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(2);
      if (!ser_le) model_sh = model_shift(model_sh, b);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic latch(input string req);
      int c0, c1;
      c0 = cnt0; c1 = cnt1;
      ser_le = 1'b1;
      if (model_sh[0]) exp1 = model_sh[W-1:1]; else exp0 = model_sh[W-1:1];
      wait_clk(8);
      check({req, " reg0"}, reg0_q, exp0);
      check({req, " reg1"}, reg1_q, exp1);
      check({req, " R7 strobe0"}, cnt0 - c0, model_sh[0] ? 0 : 1);
      check({req, " R7 strobe1"}, cnt1 - c1, model_sh[0] ? 1 : 0);
      ser_le = 1'b0;
      wait_clk(6);
      check("R4 le fall reg0", reg0_q, exp0);
      check("R4 le fall reg1", reg1_q, exp1);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
      model_sh = '0; exp0 = D0; exp1 = D1;
      wait_clk(3);
      check("R1 reset reg0", reg0_q, D0);
      check("R1 reset reg1", reg1_q, D1);
      check("R1 reset strobes", {reg0_upd, reg1_upd}, 0);
      rst_n = 1'b1;
      wait_clk(3);
      check("R1 after release reg0", reg0_q, D0);
      check("R1 after release reg1", reg1_q, D1);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      do_reset();

      // R2 R5 R3: directed word to reg0, data 17'h15555, address 0
      send_bits({17'h15555, 1'b0}, 18);
      check("R4 no latch yet reg0", reg0_q, D0);
      latch("R2 R5 R3 addr0");

      // R3: address 1, reg0 must stay
      send_bits({17'h0ABCD, 1'b1}, 18);
      latch("R3 addr1");

      // R4: clocks while le high are ignored
      send_bits({17'h1FFFF, 1'b0}, 18);
      ser_le = 1'b1;
      exp0 = model_sh[W-1:1];
      wait_clk(8);
      send_bits(32'h3, 2);
      check("R4 clk during le reg0", reg0_q, exp0);
      check("R4 clk during le reg1", reg1_q, exp1);
      ser_le = 1'b0;
      wait_clk(6);

      // R6: over-length word, 24 bits
      send_bits({6'h3F, 17'h00F0F, 1'b1}, 24);
      latch("R6 overlength");

      // R8: short word after reset
      do_reset();
      send_bits(32'b10111, 5);
      latch("R8 short after reset");

      // random mix
      for (int t = 0; t < 24; t++) begin
         int n;
         logic [31:0] v;
         n = 18 + int'($urandom_range(0, 6));
         v = $urandom();
         send_bits(v, n);
         latch("R2 R3 R6 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule